// File: doc/BRIEF.md
# Age-Ordered Collapsing Issue Queue

This block holds decoded micro-ops that are waiting for their source operands. Each held entry carries a payload, one physical register tag per source operand and a presence bit for each of those operands. Slot 0 is the top of the queue and holds the oldest entry. Newly dispatched micro-ops always join directly below the youngest entry that survives the cycle. When the external select logic grants a slot, that entry leaves the queue. Every younger entry then moves up to close the hole. Because of this, slot index and age always agree, and a priority encoder that scans from slot 0 downward picks the oldest ready micro-op.

Two kinds of wakeup broadcast set presence bits: fast ones from ALU issue and slow ones from register-file writeback. A broadcast whose tag matches an operand marks that operand present. The match is applied to the entry's contents before the entry moves, so the result lands at the entry's new position. A broadcast also applies to a micro-op that is being dispatched in the same cycle. A slot requests issue once it is valid and every one of its operands is present.

Dispatch takes up to `DISP_W` micro-ops per cycle as an all-or-nothing group. The group is accepted only when the slots left free after this cycle's removals number at least `DISP_W`. A flush empties the queue.

Top module: `age_issue_queue`

## Requirements
- R1: When reset is released, every slot is empty, `slot_req` is all zero and `disp_ready` is 1.
- R2: Valid entries always fill slots 0 up to count-1 with no gap, so `slot_valid` has the form of a run of ones starting at bit 0.
- R3: Accepted dispatch lanes take the first slots below the surviving entries. Lower lane indices take higher slots, and lanes whose `disp_valid` bit is 0 leave no gap.
- R4: A granted slot that is requesting is removed one cycle later. The surviving entries keep their relative order and each moves up by the number of removed entries above it, so an entry moves up by at most `NUM_ISSUE` slots.
- R5: `slot_req[i]` is 1 exactly when slot i is valid and all `NUM_SRC` presence bits of that slot are set.
- R6: A valid fast wakeup whose tag equals an operand's tag sets that operand's presence bit from the next cycle on. This includes an entry that moves in the same cycle.
- R7: A valid slow wakeup has the same effect as a fast wakeup, including on an entry that moves in the same cycle.
- R8: A wakeup in the same cycle as a dispatch marks a matching operand of the dispatched micro-op as present.
- R9: `disp_ready` equals (!flush && DEPTH - survivors >= DISP_W). Survivors are the valid slots that are not both granted and requesting. While `disp_ready` is 0, dispatch lanes have no effect.
- R10: A flush leaves every slot empty on the next cycle and discards any dispatch made in the same cycle.
- R11: A grant bit on a slot whose `slot_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the queue |
| disp_valid | input | DISP_W | Per-lane dispatch valid |
| disp_payload | input | DISP_W*PAY_W | Lane l payload at bits [l*PAY_W +: PAY_W] |
| disp_src_tag | input | DISP_W*NUM_SRC*TAG_W | Operand s of lane l at index (l*NUM_SRC+s)*TAG_W |
| disp_src_rdy | input | DISP_W*NUM_SRC | Operand s of lane l already present, bit l*NUM_SRC+s |
| disp_ready | output | 1 | Dispatch group is accepted this cycle |
| fast_wk_valid | input | NUM_FAST | Fast wakeup valid per port |
| fast_wk_tag | input | NUM_FAST*TAG_W | Fast wakeup tags |
| slow_wk_valid | input | NUM_SLOW | Slow wakeup valid per port |
| slow_wk_tag | input | NUM_SLOW*TAG_W | Slow wakeup tags |
| issue_grant | input | DEPTH | Select result, one bit per slot |
| slot_valid | output | DEPTH | Slot occupancy, bit 0 is the oldest |
| slot_req | output | DEPTH | Per-slot issue request |
| slot_payload | output | DEPTH*PAY_W | Payload of slot i at [i*PAY_W +: PAY_W] |

## Verification
The assertions take for granted that the external select grants no more than `NUM_ISSUE` slots that are actually requesting. They also assume a flush is never combined with an expectation that a dispatch survives. The random stimulus keeps within these assumptions by choosing grants only from slots that request, and it stops after `NUM_ISSUE` grants. Spurious grant bits on idle slots are driven on purpose, because the design must ignore them. Tags are drawn from a narrow range so that wakeups frequently match entries that are moving or being dispatched.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IQ_VEC_MAX = 64;

  // number of set bits in v strictly below position idx
  function automatic int ones_below(input logic [IQ_VEC_MAX-1:0] v, input int idx);
    int c;
    c = 0;
    for (int k = 0; k < IQ_VEC_MAX; k++) begin
      if (k < idx && v[k]) c++;
    end
    return c;
  endfunction

  // room left after a cycle given slot count and survivors
  function automatic int room_after(input int depth, input int survivors);
    return depth - survivors;
  endfunction
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
  parameter int N        = 8,
  parameter int NUM_SRC  = 2,
  parameter int TAG_W    = 6,
  parameter int NUM_FAST = 2,
  parameter int NUM_SLOW = 1
) (
  input  logic [N*NUM_SRC*TAG_W-1:0] tag,
  input  logic [N*NUM_SRC-1:0]       rdy_in,
  input  logic [NUM_FAST-1:0]        fast_vld,
  input  logic [NUM_FAST*TAG_W-1:0]  fast_tag,
  input  logic [NUM_SLOW-1:0]        slow_vld,
  input  logic [NUM_SLOW*TAG_W-1:0]  slow_tag,
  output logic [N*NUM_SRC-1:0]       rdy_out
);
  localparam int OPS = N * NUM_SRC;

  for (genvar o = 0; o < OPS; o++) begin : g_op
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int f = 0; f < NUM_FAST; f++) begin
        if (fast_vld[f] && fast_tag[f*TAG_W +: TAG_W] == tag[o*TAG_W +: TAG_W]) hit = 1'b1;
      end
      for (int w = 0; w < NUM_SLOW; w++) begin
        if (slow_vld[w] && slow_tag[w*TAG_W +: TAG_W] == tag[o*TAG_W +: TAG_W]) hit = 1'b1;
      end
    end
    assign rdy_out[o] = rdy_in[o] | hit;
  end
endmodule

// File: rtl/iq_collapse.sv
module iq_collapse
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NUM_SRC = 2,
  parameter int TAG_W   = 6,
  parameter int PAY_W   = 8,
  parameter int CNT_W   = 4
) (
  input  logic [DEPTH-1:0]               vld,
  input  logic [DEPTH-1:0]               issue,
  input  logic [DEPTH*NUM_SRC-1:0]       rdy,
  input  logic [DEPTH*NUM_SRC*TAG_W-1:0] tag,
  input  logic [DEPTH*PAY_W-1:0]         pay,
  output logic [DEPTH-1:0]               sh_vld,
  output logic [DEPTH*NUM_SRC-1:0]       sh_rdy,
  output logic [DEPTH*NUM_SRC*TAG_W-1:0] sh_tag,
  output logic [DEPTH*PAY_W-1:0]         sh_pay,
  output logic [CNT_W-1:0]               surv_cnt
);
  localparam int OP_TAG_W = NUM_SRC * TAG_W;

  logic [DEPTH-1:0] keep;
  assign keep     = vld & ~issue;
  assign surv_cnt = CNT_W'(ones_below(IQ_VEC_MAX'(keep), DEPTH));

  // each survivor lands at the count of survivors above it
  always_comb begin
    sh_vld = '0;
    sh_rdy = '0;
    sh_tag = '0;
    sh_pay = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (j == ones_below(IQ_VEC_MAX'(keep), i)) begin
            sh_vld[j]                          = 1'b1;
            sh_rdy[j*NUM_SRC +: NUM_SRC]       = rdy[i*NUM_SRC +: NUM_SRC];
            sh_tag[j*OP_TAG_W +: OP_TAG_W]     = tag[i*OP_TAG_W +: OP_TAG_W];
            sh_pay[j*PAY_W +: PAY_W]           = pay[i*PAY_W +: PAY_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
  import iq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NUM_SRC = 2,
  parameter int TAG_W   = 6,
  parameter int PAY_W   = 8,
  parameter int DISP_W  = 2,
  parameter int CNT_W   = 4
) (
  input  logic                            flush,
  input  logic [CNT_W-1:0]                surv_cnt,
  input  logic [DISP_W-1:0]               lane_vld,
  input  logic [DISP_W*NUM_SRC-1:0]       lane_rdy,
  input  logic [DISP_W*NUM_SRC*TAG_W-1:0] lane_tag,
  input  logic [DISP_W*PAY_W-1:0]         lane_pay,
  output logic                            accept,
  output logic [CNT_W-1:0]                acc_cnt,
  output logic [DEPTH-1:0]                ins_vld,
  output logic [DEPTH*NUM_SRC-1:0]        ins_rdy,
  output logic [DEPTH*NUM_SRC*TAG_W-1:0]  ins_tag,
  output logic [DEPTH*PAY_W-1:0]          ins_pay
);
  localparam int OP_TAG_W = NUM_SRC * TAG_W;

  assign accept  = !flush && (room_after(DEPTH, int'(surv_cnt)) >= DISP_W);
  assign acc_cnt = accept ? CNT_W'(ones_below(IQ_VEC_MAX'(lane_vld), DISP_W)) : '0;

  // compact valid lanes in lane order under the survivors
  always_comb begin
    ins_vld = '0;
    ins_rdy = '0;
    ins_tag = '0;
    ins_pay = '0;
    for (int l = 0; l < DISP_W; l++) begin
      if (accept && lane_vld[l]) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (j == int'(surv_cnt) + ones_below(IQ_VEC_MAX'(lane_vld), l)) begin
            ins_vld[j]                      = 1'b1;
            ins_rdy[j*NUM_SRC +: NUM_SRC]   = lane_rdy[l*NUM_SRC +: NUM_SRC];
            ins_tag[j*OP_TAG_W +: OP_TAG_W] = lane_tag[l*OP_TAG_W +: OP_TAG_W];
            ins_pay[j*PAY_W +: PAY_W]       = lane_pay[l*PAY_W +: PAY_W];
          end
        end
      end
    end
  end
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int DEPTH     = 8,
  parameter int NUM_SRC   = 2,
  parameter int TAG_W     = 6,
  parameter int PAY_W     = 8,
  parameter int DISP_W    = 2,
  parameter int NUM_ISSUE = 2,
  parameter int NUM_FAST  = 2,
  parameter int NUM_SLOW  = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic [DISP_W-1:0]               disp_valid,
  input  logic [DISP_W*PAY_W-1:0]         disp_payload,
  input  logic [DISP_W*NUM_SRC*TAG_W-1:0] disp_src_tag,
  input  logic [DISP_W*NUM_SRC-1:0]       disp_src_rdy,
  output logic                            disp_ready,
  input  logic [NUM_FAST-1:0]             fast_wk_valid,
  input  logic [NUM_FAST*TAG_W-1:0]       fast_wk_tag,
  input  logic [NUM_SLOW-1:0]             slow_wk_valid,
  input  logic [NUM_SLOW*TAG_W-1:0]       slow_wk_tag,
  input  logic [DEPTH-1:0]                issue_grant,
  output logic [DEPTH-1:0]                slot_valid,
  output logic [DEPTH-1:0]                slot_req,
  output logic [DEPTH*PAY_W-1:0]          slot_payload
);
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam int OP_TAG_W = NUM_SRC * TAG_W;

  logic [DEPTH-1:0]               ent_vld;
  logic [DEPTH*NUM_SRC-1:0]       ent_rdy;
  logic [DEPTH*NUM_SRC*TAG_W-1:0] ent_tag;
  logic [DEPTH*PAY_W-1:0]         ent_pay;

  // named internal events
  logic [DEPTH-1:0]               issue;
  logic [DEPTH*NUM_SRC-1:0]       woke_rdy;
  logic [DISP_W*NUM_SRC-1:0]      lane_woke_rdy;
  logic [DEPTH-1:0]               sh_vld;
  logic [DEPTH*NUM_SRC-1:0]       sh_rdy;
  logic [DEPTH*NUM_SRC*TAG_W-1:0] sh_tag;
  logic [DEPTH*PAY_W-1:0]         sh_pay;
  logic [CNT_W-1:0]               surv_cnt;
  logic [CNT_W-1:0]               acc_cnt;
  logic [DEPTH-1:0]               ins_vld;
  logic [DEPTH*NUM_SRC-1:0]       ins_rdy;
  logic [DEPTH*NUM_SRC*TAG_W-1:0] ins_tag;
  logic [DEPTH*PAY_W-1:0]         ins_pay;

  for (genvar i = 0; i < DEPTH; i++) begin : g_req
    assign slot_req[i] = ent_vld[i] & (&ent_rdy[i*NUM_SRC +: NUM_SRC]);
  end

  assign issue        = issue_grant & slot_req;
  assign slot_valid   = ent_vld;
  assign slot_payload = ent_pay;

  iq_wakeup #(.N(DEPTH), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W),
              .NUM_FAST(NUM_FAST), .NUM_SLOW(NUM_SLOW)) u_wk_slots (
    .tag(ent_tag), .rdy_in(ent_rdy),
    .fast_vld(fast_wk_valid), .fast_tag(fast_wk_tag),
    .slow_vld(slow_wk_valid), .slow_tag(slow_wk_tag),
    .rdy_out(woke_rdy)
  );

  iq_wakeup #(.N(DISP_W), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W),
              .NUM_FAST(NUM_FAST), .NUM_SLOW(NUM_SLOW)) u_wk_lanes (
    .tag(disp_src_tag), .rdy_in(disp_src_rdy),
    .fast_vld(fast_wk_valid), .fast_tag(fast_wk_tag),
    .slow_vld(slow_wk_valid), .slow_tag(slow_wk_tag),
    .rdy_out(lane_woke_rdy)
  );

  iq_collapse #(.DEPTH(DEPTH), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W),
                .PAY_W(PAY_W), .CNT_W(CNT_W)) u_collapse (
    .vld(ent_vld), .issue(issue), .rdy(woke_rdy), .tag(ent_tag), .pay(ent_pay),
    .sh_vld(sh_vld), .sh_rdy(sh_rdy), .sh_tag(sh_tag), .sh_pay(sh_pay),
    .surv_cnt(surv_cnt)
  );

  iq_dispatch #(.DEPTH(DEPTH), .NUM_SRC(NUM_SRC), .TAG_W(TAG_W), .PAY_W(PAY_W),
                .DISP_W(DISP_W), .CNT_W(CNT_W)) u_dispatch (
    .flush(flush), .surv_cnt(surv_cnt),
    .lane_vld(disp_valid), .lane_rdy(lane_woke_rdy),
    .lane_tag(disp_src_tag), .lane_pay(disp_payload),
    .accept(disp_ready), .acc_cnt(acc_cnt),
    .ins_vld(ins_vld), .ins_rdy(ins_rdy), .ins_tag(ins_tag), .ins_pay(ins_pay)
  );

  logic [DEPTH-1:0]               nxt_vld;
  logic [DEPTH*NUM_SRC-1:0]       nxt_rdy;
  logic [DEPTH*NUM_SRC*TAG_W-1:0] nxt_tag;
  logic [DEPTH*PAY_W-1:0]         nxt_pay;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      if (ins_vld[j]) begin
        nxt_vld[j]                      = 1'b1;
        nxt_rdy[j*NUM_SRC +: NUM_SRC]   = ins_rdy[j*NUM_SRC +: NUM_SRC];
        nxt_tag[j*OP_TAG_W +: OP_TAG_W] = ins_tag[j*OP_TAG_W +: OP_TAG_W];
        nxt_pay[j*PAY_W +: PAY_W]       = ins_pay[j*PAY_W +: PAY_W];
      end else begin
        nxt_vld[j]                      = sh_vld[j];
        nxt_rdy[j*NUM_SRC +: NUM_SRC]   = sh_rdy[j*NUM_SRC +: NUM_SRC];
        nxt_tag[j*OP_TAG_W +: OP_TAG_W] = sh_tag[j*OP_TAG_W +: OP_TAG_W];
        nxt_pay[j*PAY_W +: PAY_W]       = sh_pay[j*PAY_W +: PAY_W];
      end
    end
    if (flush) nxt_vld = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      ent_rdy <= '0;
      ent_tag <= '0;
      ent_pay <= '0;
    end else begin
      ent_vld <= nxt_vld;
      ent_rdy <= nxt_rdy;
      ent_tag <= nxt_tag;
      ent_pay <= nxt_pay;
    end
  end

  // assertions
  for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_chk_packed
    a_r2_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ent_vld[i+1] |-> ent_vld[i]);
  end

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_vld == '0));

  a_r3_count_balance: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ($countones(ent_vld) == $past(int'(surv_cnt) + int'(acc_cnt))));

  a_r9_blocked_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |=> ($countones(ent_vld) <= $past(int'(surv_cnt))));

  a_r4_issue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issue) <= NUM_ISSUE);
endmodule

// File: tb/age_issue_queue_tb_top.sv
`timescale 1ns/1ps
module age_issue_queue_tb_top;
  localparam int DEPTH = 8, NUM_SRC = 2, TAG_W = 6, PAY_W = 8, DISP_W = 2;
  localparam int NUM_ISSUE = 2, NUM_FAST = 2, NUM_SLOW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [DISP_W-1:0]               disp_valid = '0;
  logic [DISP_W*PAY_W-1:0]         disp_payload = '0;
  logic [DISP_W*NUM_SRC*TAG_W-1:0] disp_src_tag = '0;
  logic [DISP_W*NUM_SRC-1:0]       disp_src_rdy = '0;
  logic                            disp_ready;
  logic [NUM_FAST-1:0]             fast_wk_valid = '0;
  logic [NUM_FAST*TAG_W-1:0]       fast_wk_tag = '0;
  logic [NUM_SLOW-1:0]             slow_wk_valid = '0;
  logic [NUM_SLOW*TAG_W-1:0]       slow_wk_tag = '0;
  logic [DEPTH-1:0]                issue_grant = '0;
  logic [DEPTH-1:0]                slot_valid;
  logic [DEPTH-1:0]                slot_req;
  logic [DEPTH*PAY_W-1:0]          slot_payload;

  always #10 clk = ~clk;

  age_issue_queue dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_payload(disp_payload),
    .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy), .disp_ready(disp_ready),
    .fast_wk_valid(fast_wk_valid), .fast_wk_tag(fast_wk_tag),
    .slow_wk_valid(slow_wk_valid), .slow_wk_tag(slow_wk_tag),
    .issue_grant(issue_grant),
    .slot_valid(slot_valid), .slot_req(slot_req), .slot_payload(slot_payload)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int unsigned seed = 32'h1d2c3b4a;
  int next_id = 1;

  // reference queue: element 0 is the oldest
  bit [PAY_W-1:0] m_pay[DEPTH];
  bit [TAG_W-1:0] m_tag[DEPTH][NUM_SRC];
  bit             m_rdy[DEPTH][NUM_SRC];
  int             m_n = 0;

  task automatic check(bit ok, string req, string phase, string what, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] %s got %0h exp %0h", req, phase, what, got, exp);
    end
  endtask

  function automatic bit hit_tag(bit [TAG_W-1:0] t);
    for (int f = 0; f < NUM_FAST; f++)
      if (fast_wk_valid[f] && fast_wk_tag[f*TAG_W +: TAG_W] == t) return 1'b1;
    for (int w = 0; w < NUM_SLOW; w++)
      if (slow_wk_valid[w] && slow_wk_tag[w*TAG_W +: TAG_W] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit m_req(int i);
    if (i >= m_n) return 1'b0;
    for (int s = 0; s < NUM_SRC; s++) if (!m_rdy[i][s]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_survivors();
    int c = 0;
    for (int i = 0; i < m_n; i++) if (!(issue_grant[i] && m_req(i))) c++;
    return c;
  endfunction

  function automatic bit m_ready();
    return !flush && (DEPTH - m_survivors() >= DISP_W);
  endfunction

  task automatic model_step();
    bit [PAY_W-1:0] np[DEPTH];
    bit [TAG_W-1:0] nt[DEPTH][NUM_SRC];
    bit             nr[DEPTH][NUM_SRC];
    int n = 0;
    bit acc = m_ready();
    if (flush) begin m_n = 0; return; end
    for (int i = 0; i < m_n; i++) begin
      if (!(issue_grant[i] && m_req(i))) begin
        np[n] = m_pay[i];
        for (int s = 0; s < NUM_SRC; s++) begin
          nt[n][s] = m_tag[i][s];
          nr[n][s] = m_rdy[i][s] | hit_tag(m_tag[i][s]);
        end
        n++;
      end
    end
    if (acc) begin
      for (int l = 0; l < DISP_W; l++) begin
        if (disp_valid[l]) begin
          np[n] = disp_payload[l*PAY_W +: PAY_W];
          for (int s = 0; s < NUM_SRC; s++) begin
            nt[n][s] = disp_src_tag[(l*NUM_SRC+s)*TAG_W +: TAG_W];
            nr[n][s] = disp_src_rdy[l*NUM_SRC+s] | hit_tag(nt[n][s]);
          end
          n++;
        end
      end
    end
    m_n = n;
    for (int i = 0; i < n; i++) begin
      m_pay[i] = np[i];
      for (int s = 0; s < NUM_SRC; s++) begin
        m_tag[i][s] = nt[i][s];
        m_rdy[i][s] = nr[i][s];
      end
    end
  endtask

  task automatic compare(string phase);
    logic [DEPTH-1:0] ev = '0, er = '0;
    for (int i = 0; i < m_n; i++) begin
      ev[i] = 1'b1;
      er[i] = m_req(i);
    end
    check(slot_valid === ev, "R2", phase, "slot_valid", int'(slot_valid), int'(ev));
    check(slot_req === er, "R5", phase, "slot_req", int'(slot_req), int'(er));
    for (int i = 0; i < m_n; i++)
      check(slot_payload[i*PAY_W +: PAY_W] === m_pay[i], "R3 R4", phase, "payload",
            int'(slot_payload[i*PAY_W +: PAY_W]), int'(m_pay[i]));
  endtask

  // called just after a falling edge with inputs driven
  task automatic commit(string phase);
    bit er;
    #1;
    er = m_ready();
    check(disp_ready === er, "R9", phase, "disp_ready", int'(disp_ready), int'(er));
    model_step();
    @(negedge clk);
    compare(phase);
  endtask

  task automatic idle_inputs();
    flush = 0; disp_valid = '0; disp_src_rdy = '0;
    fast_wk_valid = '0; slow_wk_valid = '0; issue_grant = '0;
  endtask

  task automatic put_lane(int l, bit [TAG_W-1:0] t0, bit [TAG_W-1:0] t1, bit r0, bit r1);
    disp_valid[l] = 1'b1;
    disp_payload[l*PAY_W +: PAY_W] = PAY_W'(next_id);
    next_id++;
    disp_src_tag[(l*NUM_SRC+0)*TAG_W +: TAG_W] = t0;
    disp_src_tag[(l*NUM_SRC+1)*TAG_W +: TAG_W] = t1;
    disp_src_rdy[l*NUM_SRC+0] = r0;
    disp_src_rdy[l*NUM_SRC+1] = r1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete got 0 exp 1");
      finish_run();
    end
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(slot_valid === '0, "R1", "reset", "slot_valid", int'(slot_valid), 0);
    check(slot_req === '0, "R1", "reset", "slot_req", int'(slot_req), 0);
    check(disp_ready === 1'b1, "R1", "reset", "disp_ready", int'(disp_ready), 1);
    @(negedge clk);

    // R3 single lane 1 only, lane 0 idle: no gap
    idle_inputs();
    put_lane(1, 6'd40, 6'd41, 1'b1, 1'b1);
    disp_valid[0] = 1'b0;
    commit("R3 sparse lanes");

    // fill with unready operands, tags 8+
    for (int c = 0; c < 4; c++) begin
      idle_inputs();
      if (m_n + DISP_W <= DEPTH) begin
        put_lane(0, TAG_W'(8 + 4*c), TAG_W'(9 + 4*c), 1'b0, 1'b0);
        put_lane(1, TAG_W'(10 + 4*c), TAG_W'(11 + 4*c), 1'b0, 1'b0);
      end
      commit("R3 fill");
    end

    // R9 full (or one free): dispatch must be ignored
    idle_inputs();
    put_lane(0, 6'd1, 6'd2, 1'b1, 1'b1);
    put_lane(1, 6'd3, 6'd4, 1'b1, 1'b1);
    commit("R9 blocked dispatch");

    // R11 grant on a slot that does not request
    idle_inputs();
    issue_grant = 8'b0000_0110;
    commit("R11 grant without request");

    // R6 fast wakeup of slot 1 operands
    idle_inputs();
    fast_wk_valid = 2'b11;
    fast_wk_tag = {m_tag[1][1], m_tag[1][0]};
    commit("R6 fast wakeup");

    // R7 grant slot 0 (ready from sparse lane) while slow-waking slot 3 as it moves
    idle_inputs();
    issue_grant = 8'b0000_0011;
    slow_wk_valid = 1'b1;
    slow_wk_tag = m_tag[3][0];
    fast_wk_valid = 2'b01;
    fast_wk_tag = {6'd0, m_tag[3][1]};
    commit("R7 slow wakeup during shift");

    // R8 wakeup in same cycle as dispatch
    idle_inputs();
    put_lane(0, 6'd50, 6'd51, 1'b0, 1'b1);
    fast_wk_valid = 2'b10;
    fast_wk_tag = {6'd50, 6'd0};
    commit("R8 wake at dispatch");

    // R10 flush with dispatch
    idle_inputs();
    flush = 1'b1;
    put_lane(0, 6'd1, 6'd1, 1'b1, 1'b1);
    commit("R10 flush");
    idle_inputs();
    commit("R10 after flush");

    // random traffic
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int g = 0;
      idle_inputs();
      flush = ($urandom % 50) == 0;
      for (int l = 0; l < DISP_W; l++)
        if ($urandom % 3 != 0)
          put_lane(l, TAG_W'($urandom % 8), TAG_W'($urandom % 8),
                   bit'($urandom % 2), bit'($urandom % 2));
      for (int f = 0; f < NUM_FAST; f++) begin
        fast_wk_valid[f] = bit'($urandom % 2);
        fast_wk_tag[f*TAG_W +: TAG_W] = TAG_W'($urandom % 8);
      end
      slow_wk_valid[0] = bit'($urandom % 2);
      slow_wk_tag = TAG_W'($urandom % 8);
      for (int i = 0; i < DEPTH; i++) begin
        if (m_req(i) && g < NUM_ISSUE && ($urandom % 3 != 0)) begin
          issue_grant[i] = 1'b1; g++;
        end else if (!m_req(i) && ($urandom % 10 == 0)) begin
          issue_grant[i] = 1'b1; // R11 ignored grant
        end
      end
      commit("random R4 R6 R7 R8 R11");
    end

    idle_inputs();
    finish_run();
  end
endmodule